// File: doc/BRIEF.md
# SDRAM Bank State Command Checker

This block watches the command pins of a single-data-rate SDRAM interface and keeps track of every bank's state. Each clock edge it decodes the command that chip select, row strobe, column strobe and write enable present together. It updates a per-bank model (idle, open, or closing) and raises a one-cycle flag when the command is not legal for the addressed bank's state, or arrives before the row-to-column or precharge delay has run out. The two delays are cycle counts supplied on input ports, so one instance can follow whatever timing the controller is set up for.

A controller or a verification environment places the block beside the memory interface as a protocol monitor. The block also keeps a copy of the last mode word that was loaded legally, and it warns when a mode load carries nonzero bits above the mode field or a nonzero bank address. The banks are modelled independently of each other, so work on one bank is never held up by a delay pending on another.

Top module: `sdram_bank_guard`

## Requirements
- R1: Command code is {cs_n, ras_n, cas_n, we_n}: 0011 activate, 0101 read, 0100 write, 0110 burst stop, 0010 precharge, 0001 refresh, 0000 load mode, 0111 no-op. Any code with cs_n high is a deselect. Deselect and no-op change no state and raise no flag.
- R2: An activate to an idle bank opens it, so bank_open[ba] is 1 and bank_idle[ba] is 0 after that edge.
- R3: An activate to a bank that is already open raises err_state, and the bank stays open.
- R4: A read or write to an open bank less than trcd_cfg cycles after its activate raises err_early. Exactly trcd_cfg cycles after is legal. A trcd_cfg of 0 behaves like 1.
- R5: A read, write, burst stop, or single-bank precharge (addr[10] low) to a bank that is not open raises err_state.
- R6: A precharge closes bank ba, or every open bank when addr[10] is high. The bank reports idle trp_cfg cycles after the precharge. An activate sent earlier raises err_early.
- R7: A refresh or load mode while any bank is not idle raises err_state, and such a load mode leaves mode_reg unchanged.
- R8: A load mode with all banks idle stores addr[9:0] into mode_reg. warn_mode is raised for any load mode with a nonzero addr[12:10] or a nonzero ba.
- R9: Banks are independent: a bank that is open and past its delay accepts reads while another bank is still inside its own delay.
- R10: err_state, err_early and warn_mode are one-cycle pulses visible in the cycle after the offending edge. A flagged command leaves every bank's state unchanged.
- R11: After reset, all banks are idle and none is open, mode_reg is 0, and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address bus; bit 10 selects all banks on precharge |
| trcd_cfg | input | 4 | Activate-to-access delay in cycles |
| trp_cfg | input | 4 | Precharge-to-idle delay in cycles |
| bank_open | output | 4 | One bit per bank, row open |
| bank_idle | output | 4 | One bit per bank, ready for activate |
| mode_reg | output | 10 | Last legally loaded mode word |
| err_state | output | 1 | Command illegal for bank state |
| err_early | output | 1 | Command issued before its delay expired |
| warn_mode | output | 1 | Load mode with nonzero reserved bits |

## Verification
The bench uses the default parameters: four banks, a 13-bit address, a 10-bit mode field, 4-bit delay counters, and registered flags. At run time it sets the row-to-column delay to 3 and the precharge delay to 2. This makes both the last early cycle and the first legal cycle of each delay reachable within a few commands. Later it sets the row-to-column delay to 0 to reach the clamp that treats zero as one cycle. With four banks, the bench can keep one bank open while a second is still inside its delay and two others stay idle. That mix covers the per-bank independence case and the precharge-all case together.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

   typedef enum logic [2:0] {
      C_NOP,
      C_ACT,
      C_RD,
      C_WR,
      C_BST,
      C_PRE,
      C_REF,
      C_LMR
   } sbg_cmd_e;

   typedef enum logic [1:0] {
      B_IDLE,
      B_OPEN,
      B_SHUT
   } sbg_bank_e;

endpackage

// File: rtl/sbg_cmd_decode.sv
module sbg_cmd_decode
   import sbg_pkg::*;
(
   input  logic     cs_n,
   input  logic     ras_n,
   input  logic     cas_n,
   input  logic     we_n,
   output sbg_cmd_e cmd
);

   always_comb begin
      cmd = C_NOP;
      if (!cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b011:  cmd = C_ACT;
            3'b101:  cmd = C_RD;
            3'b100:  cmd = C_WR;
            3'b110:  cmd = C_BST;
            3'b010:  cmd = C_PRE;
            3'b001:  cmd = C_REF;
            3'b000:  cmd = C_LMR;
            default: cmd = C_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sbg_bank.sv
module sbg_bank
   import sbg_pkg::*;
#(
   parameter int TIMER_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  sbg_cmd_e           cmd,
   input  logic               sel,
   input  logic               pre_all,
   input  logic [TIMER_W-1:0] rcd_cfg,
   input  logic [TIMER_W-1:0] rp_cfg,
   output logic               is_open,
   output logic               is_idle,
   output logic               bad_state,
   output logic               bad_early
);

   sbg_bank_e          st, st_nx;
   logic [TIMER_W-1:0] cnt, cnt_nx;
   logic [TIMER_W-1:0] ld_rcd, ld_rp;

   assign ld_rcd  = (rcd_cfg == '0) ? '0 : rcd_cfg - TIMER_W'(1);
   assign ld_rp   = (rp_cfg  == '0) ? '0 : rp_cfg  - TIMER_W'(1);
   assign is_open = (st == B_OPEN);
   assign is_idle = (st == B_IDLE) || (st == B_SHUT && cnt == '0);

   always_comb begin
      st_nx     = st;
      cnt_nx    = (cnt != '0) ? cnt - TIMER_W'(1) : cnt;
      bad_state = 1'b0;
      bad_early = 1'b0;
      if (st == B_SHUT && cnt == '0) st_nx = B_IDLE;
      case (cmd)
         C_ACT: if (sel) begin
            if (is_idle) begin
               st_nx  = B_OPEN;
               cnt_nx = ld_rcd;
            end else if (st == B_SHUT) begin
               bad_early = 1'b1;
            end else begin
               bad_state = 1'b1;
            end
         end
         C_RD, C_WR: if (sel) begin
            if (!is_open)         bad_state = 1'b1;
            else if (cnt != '0)   bad_early = 1'b1;
         end
         C_BST: if (sel && !is_open) bad_state = 1'b1;
         C_PRE: if (sel || pre_all) begin
            if (is_open) begin
               st_nx  = B_SHUT;
               cnt_nx = ld_rp;
            end else if (!pre_all) begin
               bad_state = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= B_IDLE;
         cnt <= '0;
      end else begin
         st  <= st_nx;
         cnt <= cnt_nx;
      end
   end

   // R2: activate on an idle bank leaves it open
   p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_ACT && sel && is_idle) |=> is_open);

   // R6: precharge of an open bank closes it
   p_pre_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_PRE && (sel || pre_all) && is_open) |=> !is_open);

   // R10: a refused activate does not change the open state
   p_refused_act_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_ACT && sel && !is_idle) |=> $stable(is_open));

endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
   import sbg_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 13,
   parameter int MODE_W    = 10,
   parameter int AP_BIT    = 10,
   parameter int TIMER_W   = 4,
   parameter bit REG_FLAGS = 1'b1,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [BA_W-1:0]      ba,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [TIMER_W-1:0]   trcd_cfg,
   input  logic [TIMER_W-1:0]   trp_cfg,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic [NUM_BANKS-1:0] bank_idle,
   output logic [MODE_W-1:0]    mode_reg,
   output logic                 err_state,
   output logic                 err_early,
   output logic                 warn_mode
);

   localparam int RSV_W = ADDR_W - MODE_W;

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (RSV_W < 1 || AP_BIT >= ADDR_W) begin : g_bad_addr
      $error("ADDR_W must exceed MODE_W and hold AP_BIT");
   end
   if (TIMER_W < 1) begin : g_bad_timer
      $error("TIMER_W must be at least 1");
   end

   sbg_cmd_e             cmd;
   logic [NUM_BANKS-1:0] bad_st_v, bad_er_v;
   logic                 all_idle;
   logic                 st_now, er_now, wn_now;

   sbg_cmd_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      sbg_bank #(.TIMER_W(TIMER_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .cmd       (cmd),
         .sel       (ba == BA_W'(g)),
         .pre_all   (addr[AP_BIT]),
         .rcd_cfg   (trcd_cfg),
         .rp_cfg    (trp_cfg),
         .is_open   (bank_open[g]),
         .is_idle   (bank_idle[g]),
         .bad_state (bad_st_v[g]),
         .bad_early (bad_er_v[g])
      );
   end

   assign all_idle = &bank_idle;
   assign st_now   = (|bad_st_v) || ((cmd == C_REF || cmd == C_LMR) && !all_idle);
   assign er_now   = |bad_er_v;
   assign wn_now   = (cmd == C_LMR) && ((addr[ADDR_W-1:MODE_W] != '0) || (ba != '0));

   always_ff @(posedge clk) begin
      if (!rst_n)                        mode_reg <= '0;
      else if (cmd == C_LMR && all_idle) mode_reg <= addr[MODE_W-1:0];
   end

   if (REG_FLAGS) begin : g_flag_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            err_state <= 1'b0;
            err_early <= 1'b0;
            warn_mode <= 1'b0;
         end else begin
            err_state <= st_now;
            err_early <= er_now;
            warn_mode <= wn_now;
         end
      end

      // R7: refresh with a bank not idle is flagged
      p_ref_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd == C_REF && !all_idle) |=> err_state);

      // R1: a deselect cycle raises no flag
      p_quiet_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
         cs_n |=> (!err_state && !err_early && !warn_mode));
   end else begin : g_flag_comb
      assign err_state = st_now;
      assign err_early = er_now;
      assign warn_mode = wn_now;
   end

   // R7: mode word only moves on a legal load
   p_lmr_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != C_LMR || !all_idle) |=> $stable(mode_reg));

   // R11: open and idle never claimed together for one bank
   p_open_idle_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_open & bank_idle) == '0);

endmodule

// File: tb/sim_sdram_bank_guard.sv
`timescale 1ns/1ps
module sim_sdram_bank_guard;

   localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD  = 4'b0101,
                          K_WR  = 4'b0100, K_BST = 4'b0110, K_PRE = 4'b0010,
                          K_REF = 4'b0001, K_LMR = 4'b0000,
                          K_DES_ACT = 4'b1011, K_DES_LMR = 4'b1000;

   typedef struct {
      logic       es, ee, ew;
      logic [3:0] op, id;
      logic [9:0] md;
      string      tag;
   } exp_t;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;
   logic [3:0]  trcd_cfg = 4'd3, trp_cfg = 4'd2;
   logic [3:0]  bank_open, bank_idle;
   logic [9:0]  mode_reg;
   logic        err_state, err_early, warn_mode;

   int   total = 0, bad = 0;
   bit   done = 1'b0;
   logic [9:0] em = '0;
   exp_t q[$];

   always #2 clk = ~clk;

   sdram_bank_guard u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .addr(addr), .trcd_cfg(trcd_cfg), .trp_cfg(trp_cfg),
      .bank_open(bank_open), .bank_idle(bank_idle), .mode_reg(mode_reg),
      .err_state(err_state), .err_early(err_early), .warn_mode(warn_mode)
   );

   task automatic iss(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a,
                      input logic es, input logic ee, input logic ew,
                      input logic [3:0] op, input logic [3:0] id, input string tag);
      exp_t it;
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = c;
      ba = b;
      addr = a;
      it.es = es; it.ee = ee; it.ew = ew;
      it.op = op; it.id = id; it.md = em; it.tag = tag;
      q.push_back(it);
   endtask

   // monitor: pops one expected item per edge and compares
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            total++;
            if ({err_state, err_early, warn_mode} != {it.es, it.ee, it.ew} ||
                bank_open != it.op || bank_idle != it.id || mode_reg != it.md) begin
               bad++;
               $display("FAIL %s: got st=%b er=%b wn=%b open=%b idle=%b mode=%h exp st=%b er=%b wn=%b open=%b idle=%b mode=%h",
                        it.tag, err_state, err_early, warn_mode, bank_open, bank_idle, mode_reg,
                        it.es, it.ee, it.ew, it.op, it.id, it.md);
            end
         end
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      {cs_n, ras_n, cas_n, we_n} = K_NOP;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      total++;
      if (bank_open != 4'b0000 || bank_idle != 4'b1111 || mode_reg != 10'h0 ||
          {err_state, err_early, warn_mode} != 3'b000) begin
         bad++;
         $display("FAIL R11: got open=%b idle=%b mode=%h flags=%b exp 0000 1111 000 000",
                  bank_open, bank_idle, mode_reg, {err_state, err_early, warn_mode});
      end
      iss(K_NOP,     2'd0, 13'h000, 0,0,0, 4'b0000, 4'b1111, "R1 nop");
      iss(K_DES_ACT, 2'd0, 13'h000, 0,0,0, 4'b0000, 4'b1111, "R1 deselect act");
      iss(K_ACT,     2'd0, 13'h000, 0,0,0, 4'b0001, 4'b1110, "R2 act b0");
      iss(K_RD,      2'd0, 13'h000, 0,1,0, 4'b0001, 4'b1110, "R4 rd early +1");
      iss(K_WR,      2'd0, 13'h000, 0,1,0, 4'b0001, 4'b1110, "R4 wr early +2");
      iss(K_RD,      2'd0, 13'h000, 0,0,0, 4'b0001, 4'b1110, "R4 rd at trcd R10 pulse ends");
      iss(K_ACT,     2'd2, 13'h000, 0,0,0, 4'b0101, 4'b1010, "R2 act b2");
      iss(K_RD,      2'd0, 13'h000, 0,0,0, 4'b0101, 4'b1010, "R9 rd b0 while b2 waits");
      iss(K_WR,      2'd2, 13'h000, 0,1,0, 4'b0101, 4'b1010, "R9 wr b2 early");
      iss(K_WR,      2'd1, 13'h000, 1,0,0, 4'b0101, 4'b1010, "R5 wr idle b1");
      iss(K_ACT,     2'd0, 13'h000, 1,0,0, 4'b0101, 4'b1010, "R3 act open b0");
      iss(K_BST,     2'd3, 13'h000, 1,0,0, 4'b0101, 4'b1010, "R5 bst idle b3");
      iss(K_PRE,     2'd3, 13'h000, 1,0,0, 4'b0101, 4'b1010, "R5 pre idle b3");
      iss(K_REF,     2'd0, 13'h000, 1,0,0, 4'b0101, 4'b1010, "R7 ref busy");
      iss(K_LMR,     2'd0, 13'h155, 1,0,0, 4'b0101, 4'b1010, "R7 lmr busy");
      iss(K_PRE,     2'd0, 13'h000, 0,0,0, 4'b0100, 4'b1010, "R6 pre b0");
      iss(K_ACT,     2'd0, 13'h000, 0,1,0, 4'b0100, 4'b1011, "R6 act b0 early R10");
      iss(K_ACT,     2'd0, 13'h000, 0,0,0, 4'b0101, 4'b1010, "R6 act b0 at trp");
      iss(K_PRE,     2'd1, 13'h400, 0,0,0, 4'b0000, 4'b1010, "R6 pre all");
      iss(K_REF,     2'd0, 13'h000, 1,0,0, 4'b0000, 4'b1111, "R7 ref closing");
      iss(K_REF,     2'd0, 13'h000, 0,0,0, 4'b0000, 4'b1111, "R7 ref idle");
      em = 10'h0A5;
      iss(K_LMR,     2'd0, 13'h0A5, 0,0,0, 4'b0000, 4'b1111, "R8 lmr clean");
      em = 10'h033;
      iss(K_LMR,     2'd0, 13'h433, 0,0,1, 4'b0000, 4'b1111, "R8 lmr high bits");
      em = 10'h011;
      iss(K_LMR,     2'd2, 13'h011, 0,0,1, 4'b0000, 4'b1111, "R8 lmr bank nonzero");
      iss(K_DES_LMR, 2'd0, 13'h3FF, 0,0,0, 4'b0000, 4'b1111, "R1 deselect lmr");
      iss(K_NOP,     2'd0, 13'h000, 0,0,0, 4'b0000, 4'b1111, "R1 nop idle");
      @(negedge clk);
      trcd_cfg = 4'd0;
      q.push_back('{es:0, ee:0, ew:0, op:4'b0000, id:4'b1111, md:em, tag:"R1 nop cfg"});
      iss(K_ACT,     2'd1, 13'h000, 0,0,0, 4'b0010, 4'b1101, "R2 act b1");
      iss(K_RD,      2'd1, 13'h000, 0,0,0, 4'b0010, 4'b1101, "R4 trcd zero clamp");
      iss(K_PRE,     2'd1, 13'h000, 0,0,0, 4'b0000, 4'b1101, "R6 pre b1");
      iss(K_NOP,     2'd0, 13'h000, 0,0,0, 4'b0000, 4'b1111, "R6 b1 idle after trp");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule